// File: doc/BRIEF.md
# Burst Pseudo-Static Memory Control Front End

This block sits on the device side of a pseudo-static memory that can run either clocked bursts or plain asynchronous accesses. It watches chip select, address strobe, output enable and write enable, captures the start address, counts off a programmable initial latency and then steps through a linear, wrapping burst. Its WAIT output tells the host, one clock ahead, whether the data bus will carry a valid word. A small storage array is included so that data written and read through the burst logic can be checked end to end.

In synchronous mode a burst is opened by a clock edge that sees chip select and the address strobe both low. Write enable at that same edge picks a write burst, otherwise a read burst. The host can pause a burst by raising output enable (read) or write enable (write). The burst ends on its own after a fixed count, or at once when chip select rises. In asynchronous mode the WAIT pin is not driven, and the address can flow straight through while the strobe is held low.

Top module: `psram_fe_top`

## Requirements
- R1: While cs_n_i is high, adv_n_i has no effect: no burst is opened, and holding cs_n_i low afterwards with adv_n_i high yields no data, WAIT stays low and perr_o stays low.
- R2: While adv_n_i is high, addr_i is ignored: a burst uses the address captured at its start, and an asynchronous read uses the last address seen with the strobe low.
- R3: In synchronous mode, a rising clock edge with cs_n_i and adv_n_i low opens a burst at addr_i; we_n_i low at that edge selects a write burst, high a read burst.
- R4: With latency L = lat_i (values below 2 count as 2) and the opening edge numbered 0, a read puts its first word on rdata_o with rvalid_o high after edge L; wait_o is low after edges 0 to L-2 and high from edge L-1 on.
- R5: A write burst drives wait_o high from the edge after the opening edge to the end of the burst; beat k stores wdata_i at the k-th edge from edge L on at which we_n_i is low.
- R6: During a burst, an edge that sees oe_n_i high (read) or we_n_i high (write) moves no data and does not advance the address, and wait_o stays high.
- R7: blen_i = 0, 1, 2 selects 4, 8 or 16 beats whose addresses increment and wrap inside the aligned block of that size; blen_i = 3 is continuous and increments modulo the array size.
- R8: A fixed-length burst ends at the edge that moves its last beat, which also drives wait_o low, and no further data follows; an edge with cs_n_i high ends any burst, including a continuous one.
- R9: A low adv_n_i after it has returned high within an open burst is ignored and raises perr_o for exactly one cycle after that edge.
- R10: wait_oe_o is high exactly while sync_mode_i is high and cs_n_i is low; low means the WAIT pad is high impedance.
- R11: In asynchronous mode (sync_mode_i low), an edge with cs_n_i and we_n_i low writes wdata_i, and an edge with cs_n_i and oe_n_i low and we_n_i high puts the word on rdata_o with rvalid_o high after that edge; with adv_n_i low the address is taken from addr_i in the same cycle.
- R12: After reset, wait_o, rvalid_o and perr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode_i | input | 1 | 1 = clocked burst mode, 0 = asynchronous mode (static) |
| lat_i | input | LAT_W | Initial read latency in clocks (static) |
| blen_i | input | 2 | Burst length code: 0=4, 1=8, 2=16, 3=continuous (static) |
| cs_n_i | input | 1 | Chip select, active low |
| adv_n_i | input | 1 | Address strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | AW | Address bus |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | rdata_o holds a freshly read word |
| wait_o | output | 1 | WAIT level: low = data in the next cycle is not valid |
| wait_oe_o | output | 1 | Drive enable for the WAIT pad |
| perr_o | output | 1 | One-cycle flag for an illegal address strobe inside a burst |

## Verification
A latency counter that is off by one shows at once as WAIT rising a cycle early or late and as the first read word landing on the wrong edge, so the bench compares WAIT on every cycle of the latency window. A burst address that fails to hold during a pause or wraps across the wrong boundary surfaces as a wrong word on the very next beat, which the scoreboard catches against a bench-side memory model computed with modulo arithmetic. A burst that survives its end or a chip-select rise shows as a stray rvalid_o one cycle later, and a stale strobe flag shows as perr_o missing or doubled in the cycle after the offending edge.

// File: rtl/psram_fe_pkg.sv
`timescale 1ns/1ps
package psram_fe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAT   = 2'd1,
        ST_BURST = 2'd2
    } fe_state_e;

    localparam logic [1:0] BLEN_CONT = 2'd3;
    localparam int         FIXED_LENS = 3;

endpackage

// File: rtl/psram_fe_wrap.sv
`timescale 1ns/1ps
module psram_fe_wrap #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] cur_i,
    input  logic [1:0]    blen_i,
    output logic [AW-1:0] nxt_o
);
    import psram_fe_pkg::*;

    logic [AW-1:0] inc_w;
    logic [AW-1:0] keep_w;

    assign inc_w = cur_i + AW'(1);

    // Upper bits outside the burst window are kept; the rest count and wrap.
    always_comb begin
        keep_w = '0;
        for (int i = 0; i < FIXED_LENS; i++) begin
            if (blen_i == 2'(i)) begin
                keep_w = ~AW'((1 << (i + 2)) - 1);
            end
        end
        nxt_o = (cur_i & keep_w) | (inc_w & ~keep_w);
    end

endmodule

// File: rtl/psram_fe_store.sv
`timescale 1ns/1ps
module psram_fe_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[addr_i] <= wdata_i;
        end
        if (rd_en_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

    // R11: the sequencer never asks for a read and a write in one cycle
    assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && wr_en_i));

endmodule

// File: rtl/psram_fe_seq.sv
`timescale 1ns/1ps
module psram_fe_seq #(
    parameter int AW         = 6,
    parameter int LAT_W      = 3,
    parameter int BL_LOG_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic [1:0]       blen_i,
    input  logic             cs_n_i,
    input  logic             adv_n_i,
    input  logic             oe_n_i,
    input  logic             we_n_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [AW-1:0]    nxt_addr_i,
    output logic [AW-1:0]    cur_addr_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic             rd_en_o,
    output logic             wr_en_o,
    output logic             rvalid_o,
    output logic             wait_o,
    output logic             perr_o
);
    import psram_fe_pkg::*;

    localparam int              CNT_W   = BL_LOG_MAX;
    localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);

    typedef struct packed {
        fe_state_e         st;
        logic              is_wr;
        logic [LAT_W-1:0]  lat_cnt;
        logic [CNT_W-1:0]  beat_cnt;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     start;
        logic              adv_hi;
        logic              wait_lvl;
        logic              rvalid;
        logic              perr;
    } seq_t;

    seq_t q, n;

    logic [LAT_W-1:0] lat_eff_w;
    logic [CNT_W-1:0] last_beat_w;
    logic             beat_w;

    assign lat_eff_w   = (lat_i < LAT_MIN) ? LAT_MIN : lat_i;
    assign last_beat_w = CNT_W'((32'd4 << blen_i) - 32'd1);
    assign beat_w      = q.is_wr ? !we_n_i : !oe_n_i;

    always_comb begin
        n          = q;
        n.perr     = 1'b0;
        n.rvalid   = 1'b0;
        rd_en_o    = 1'b0;
        wr_en_o    = 1'b0;
        mem_addr_o = q.addr;

        if (!sync_mode_i) begin
            // Asynchronous: transparent latch while the strobe is low.
            n.st       = ST_IDLE;
            n.wait_lvl = 1'b0;
            if (!cs_n_i && !adv_n_i) begin
                n.addr     = addr_i;
                mem_addr_o = addr_i;
            end
            if (!cs_n_i && !we_n_i) begin
                wr_en_o = 1'b1;
            end else if (!cs_n_i && !oe_n_i) begin
                rd_en_o  = 1'b1;
                n.rvalid = 1'b1;
            end
        end else if (cs_n_i) begin
            n.st       = ST_IDLE;
            n.wait_lvl = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    n.wait_lvl = 1'b0;
                    if (!adv_n_i) begin
                        n.st       = ST_LAT;
                        n.addr     = addr_i;
                        n.start    = addr_i;
                        n.is_wr    = !we_n_i;
                        n.lat_cnt  = lat_eff_w - LAT_W'(1);
                        n.beat_cnt = '0;
                        n.adv_hi   = 1'b0;
                        n.wait_lvl = !we_n_i;
                    end
                end
                ST_LAT: begin
                    n.lat_cnt = q.lat_cnt - LAT_W'(1);
                    if (q.lat_cnt == LAT_W'(1)) begin
                        n.st       = ST_BURST;
                        n.wait_lvl = 1'b1;
                    end
                end
                ST_BURST: begin
                    if (beat_w) begin
                        rd_en_o    = !q.is_wr;
                        wr_en_o    = q.is_wr;
                        n.rvalid   = !q.is_wr;
                        n.addr     = nxt_addr_i;
                        n.beat_cnt = q.beat_cnt + CNT_W'(1);
                        if (blen_i != BLEN_CONT && q.beat_cnt == last_beat_w) begin
                            n.st       = ST_IDLE;
                            n.wait_lvl = 1'b0;
                        end
                    end
                end
                default: begin
                    n.st       = ST_IDLE;
                    n.wait_lvl = 1'b0;
                end
            endcase

            // Strobe watch inside an open burst: a fresh low is a protocol error.
            if (q.st != ST_IDLE) begin
                if (adv_n_i) begin
                    n.adv_hi = 1'b1;
                end else if (q.adv_hi) begin
                    n.perr   = 1'b1;
                    n.adv_hi = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, is_wr: 1'b0, lat_cnt: '0, beat_cnt: '0,
                   addr: '0, start: '0, adv_hi: 1'b0, wait_lvl: 1'b0,
                   rvalid: 1'b0, perr: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign cur_addr_o = q.addr;
    assign rvalid_o   = q.rvalid;
    assign wait_o     = q.wait_lvl;
    assign perr_o     = q.perr;

    // R6: a paused beat keeps WAIT high and the burst address frozen
    assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_i && !cs_n_i && q.st == ST_BURST && !beat_w)
        |=> (q.wait_lvl && $stable(q.addr)));

    // R9: the protocol error flag is a single-cycle pulse
    assert_perr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> !perr_o);

    // R4: no data moves while the initial latency runs
    assert_no_beat_in_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LAT) |-> !(rd_en_o || wr_en_o));

    // R7: a fixed-length burst stays inside its aligned window
    assert_addr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BURST && blen_i != BLEN_CONT)
        |-> (((q.addr ^ q.start) >> (32'(blen_i) + 32'd2)) == '0));

endmodule

// File: rtl/psram_fe_top.sv
`timescale 1ns/1ps
module psram_fe_top #(
    parameter int AW         = 6,
    parameter int DW         = 16,
    parameter int LAT_W      = 3,
    parameter int BL_LOG_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic [1:0]       blen_i,
    input  logic             cs_n_i,
    input  logic             adv_n_i,
    input  logic             oe_n_i,
    input  logic             we_n_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             rvalid_o,
    output logic             wait_o,
    output logic             wait_oe_o,
    output logic             perr_o
);
    logic [AW-1:0] cur_addr_w;
    logic [AW-1:0] nxt_addr_w;
    logic [AW-1:0] mem_addr_w;
    logic          rd_en_w;
    logic          wr_en_w;

    psram_fe_wrap #(.AW(AW)) u_wrap (
        .cur_i  (cur_addr_w),
        .blen_i (blen_i),
        .nxt_o  (nxt_addr_w)
    );

    psram_fe_seq #(.AW(AW), .LAT_W(LAT_W), .BL_LOG_MAX(BL_LOG_MAX)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode_i (sync_mode_i),
        .lat_i       (lat_i),
        .blen_i      (blen_i),
        .cs_n_i      (cs_n_i),
        .adv_n_i     (adv_n_i),
        .oe_n_i      (oe_n_i),
        .we_n_i      (we_n_i),
        .addr_i      (addr_i),
        .nxt_addr_i  (nxt_addr_w),
        .cur_addr_o  (cur_addr_w),
        .mem_addr_o  (mem_addr_w),
        .rd_en_o     (rd_en_w),
        .wr_en_o     (wr_en_w),
        .rvalid_o    (rvalid_o),
        .wait_o      (wait_o),
        .perr_o      (perr_o)
    );

    psram_fe_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_en_w),
        .wr_en_i (wr_en_w),
        .addr_i  (mem_addr_w),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    assign wait_oe_o = sync_mode_i & ~cs_n_i;

    // R4: every synchronous read word was announced by WAIT one cycle earlier
    assert_rvalid_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_i && $past(sync_mode_i) && rvalid_o) |-> $past(wait_o));

endmodule

// File: tb/tb_psram_fe_top.sv
`timescale 1ns/1ps
module tb_psram_fe_top;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int LAT_W = 3;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_mode = 1'b0;
    logic [LAT_W-1:0] lat = LAT_W'(3);
    logic [1:0]       blen = 2'd0;
    logic             cs_n = 1'b1;
    logic             adv_n = 1'b1;
    logic             oe_n = 1'b1;
    logic             we_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata_o;
    logic             rvalid_o, wait_o, wait_oe_o, perr_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] exp_w;

    always #2 clk = ~clk;

    psram_fe_top #(.AW(AW), .DW(DW), .LAT_W(LAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .sync_mode_i(sync_mode), .lat_i(lat),
        .blen_i(blen), .cs_n_i(cs_n), .adv_n_i(adv_n), .oe_n_i(oe_n),
        .we_n_i(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .wait_o(wait_o), .wait_oe_o(wait_oe_o),
        .perr_o(perr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int a, input int bl, input int k);
        int len;
        int base;
        len  = (bl == 3) ? DEPTH : (4 << bl);
        base = a - (a % len);
        return base + ((a - base + k) % len);
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Scoreboard monitor: pops one expected word per valid output
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R3 unexpected word act=%0h exp=none", rdata_o);
            end else begin
                exp_w = exp_q.pop_front();
                chk("R3 R7 R11 read data", 32'(rdata_o), 32'(exp_w));
            end
        end
    end

    task automatic sync_read(input int a, input int l, input int bl, input int nb,
                             input int pause_at, input int err_at);
        int  done;
        bit  paused;
        for (int k = 0; k < nb; k++) exp_q.push_back(model[AW'(exp_addr(a, bl, k))]);
        lat = LAT_W'(l); blen = 2'(bl);
        cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = AW'(a);
        @(negedge clk);
        oe_n = 1'b0;
        for (int k = 0; k < l; k++) begin
            chk("R4 wait during latency", 32'(wait_o), 32'(k >= l - 1));
            chk("R4 no data during latency", 32'(rvalid_o), 32'(0));
            chk("R9 perr timing", 32'(perr_o), 32'(err_at >= 0 && k == err_at + 1));
            adv_n = (k == err_at) ? 1'b0 : 1'b1;
            addr  = (k == err_at) ? AW'(a ^ 5) : ~AW'(a);   // R2: ignored
            @(negedge clk);
        end
        done = 1; paused = 1'b0;
        while (done < nb) begin
            chk("R4 wait high in burst", 32'(wait_o), 32'(1));
            if (done == pause_at && !paused) begin
                oe_n = 1'b1; paused = 1'b1;
                @(negedge clk);
                chk("R6 read pause no data", 32'(rvalid_o), 32'(0));
                chk("R6 read pause wait", 32'(wait_o), 32'(1));
                oe_n = 1'b0;
            end
            @(negedge clk);
            done++;
        end
        if (bl != 3) chk("R8 wait low at end", 32'(wait_o), 32'(0));
        else cs_n = 1'b1;
        @(negedge clk);
        chk("R8 no data after end", 32'(rvalid_o), 32'(0));
        if (bl == 3) chk("R10 pad released", 32'(wait_oe_o), 32'(0));
        cs_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sync_write(input int a, input int l, input int bl, input int nb,
                              input int pause_at, input int seed);
        int  done;
        bit  paused;
        logic [DW-1:0] d;
        lat = LAT_W'(l); blen = 2'(bl);
        cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(a);
        @(negedge clk);
        for (int k = 0; k < l - 1; k++) begin
            chk("R5 wait high in write latency", 32'(wait_o), 32'(1));
            adv_n = 1'b1; addr = ~AW'(a);
            @(negedge clk);
        end
        done = 0; paused = 1'b0;
        while (done < nb) begin
            if (done == pause_at && !paused) begin
                we_n = 1'b1; paused = 1'b1;
                @(negedge clk);
                chk("R6 write pause wait", 32'(wait_o), 32'(1));
                we_n = 1'b0;
            end
            d = DW'(seed + done * 17);
            wdata = d;
            @(negedge clk);
            model[AW'(exp_addr(a, bl, done))] = d;
            chk("R5 R8 wait in write", 32'(wait_o), 32'(done != nb - 1));
            done++;
        end
        we_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset wait", 32'(wait_o), 32'(0));
        chk("R12 reset rvalid", 32'(rvalid_o), 32'(0));
        chk("R12 reset perr", 32'(perr_o), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R11: fill the array with asynchronous writes, strobe held low
        sync_mode = 1'b0; cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a);
            wdata = DW'((a * 16'h0101) ^ 16'h3C5A);
            model[a] = wdata;
            @(negedge clk);
        end
        chk("R10 async pad released", 32'(wait_oe_o), 32'(0));

        // R11 and R2: asynchronous reads, pass-through then held address
        we_n = 1'b1; oe_n = 1'b0; addr = AW'(10);
        exp_q.push_back(model[10]);
        @(negedge clk);
        addr = AW'(11);
        exp_q.push_back(model[11]);
        @(negedge clk);
        adv_n = 1'b1; addr = AW'(40);
        exp_q.push_back(model[11]);
        @(negedge clk);
        chk("R10 async wait not driven", 32'(wait_oe_o), 32'(0));
        cs_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        chk("R11 async reads consumed", 32'(exp_q.size()), 32'(0));

        // R1: strobe with chip select high opens nothing
        sync_mode = 1'b1; lat = LAT_W'(3); blen = 2'd0;
        adv_n = 1'b0; addr = AW'(7);
        @(negedge clk);
        chk("R10 pad off with cs high", 32'(wait_oe_o), 32'(0));
        @(negedge clk);
        cs_n = 1'b0; adv_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk("R10 pad on with cs low", 32'(wait_oe_o), 32'(1));
        for (int k = 0; k < 5; k++) begin
            chk("R1 no burst from ignored strobe", 32'({rvalid_o, wait_o, perr_o}), 32'(0));
            @(negedge clk);
        end
        cs_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);

        // R3 R4 R7: reads across lengths and latencies
        sync_read(6, 3, 0, 4, -1, -1);
        sync_read(13, 4, 1, 8, 3, -1);       // R6 pause
        sync_read(30, 2, 2, 16, 5, -1);
        sync_read(2, 5, 0, 4, -1, 1);        // R9 illegal strobe
        sync_read(62, 3, 3, 5, 2, -1);       // continuous, cs terminates

        // R5 R6: write bursts then read them back
        sync_write(9, 3, 1, 8, 3, 16'hA000);
        sync_read(8, 4, 1, 8, 2, -1);
        sync_write(33, 5, 0, 4, 0, 16'h5100);
        sync_read(35, 3, 0, 4, -1, -1);

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'(0));
        finish_run();
    end

endmodule